// File: doc/BRIEF.md
# Bridge Control Register Bank

A word-organised bank of 28 configuration registers for a host bridge. It holds the general configuration word, GPIO settings, the interrupt-controller setup, four mailboxes, cache control and timing words. Every register sits at a byte offset four times its index, inside a window of 0x70 bytes. Only whole, aligned 32-bit words are accepted.

The interrupt-enable word cannot be written directly. Software sets bits through a set alias and clears them through a clear alias. Both aliases also keep the last value written to them. Writes to the enable word and to the interrupt status word are dropped. When a write moves the self-reset bit of the general configuration word from 0 to 1, the bank stores the new word and emits a one-cycle system-reset request. On reset the bank loads fixed default values.

The host side is a single request port: valid, write and a byte address, with write data. A read returns its word one cycle later, flagged by a read-valid strobe.

Top module: `bridge_ctl_regs`

## Requirements
- R1: A read request with an aligned byte address below 0x70 returns the word at index address/4. The read-valid output is high, with the data, during the cycle after the request edge.
- R2: After reset the registers read as follows. Index 0 holds 0xC40. Index 1 holds 0x1384 (bits 2, 7, 8, 9 and 12 set). Index 2 holds 0x2BFF8010. Index 3 holds 0x255E0091. Index 4 holds 0x6140. Indexes 7 and 8 hold 0x1FF. Index 26 holds 0x8. Index 27 holds 0x10000000. Every other index holds 0.
- R3: A write to any aligned in-window offset other than 0x30, 0x34, 0x38 and 0x3C stores the full 32-bit data word at that index.
- R4: A write to offset 0x30 stores the data at 0x30 and ORs the data into the enable word at offset 0x38.
- R5: A write to offset 0x34 stores the data at 0x34 and clears, in the enable word, every bit that is 1 in the data.
- R6: Writes to offsets 0x38 (enable) and 0x3C (status) change nothing. The status word reads 0.
- R7: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, drives the reset request output high for exactly the one cycle after the write edge. The written word is still stored.
- R8: A write to offset 0x04 with bit 2 clear, or made while the stored bit 2 is already 1, raises no reset request.
- R9: A write whose address has nonzero bits [1:0], or whose address is 0x70 or above, changes no register. A read of such an address returns 0.
- R10: Read-valid is low after any cycle without a read request, including a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address in the bank |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
A write takes effect at the clock edge that accepts it. The reset request comes from a register loaded at that same edge, so it is high during the following cycle and low in the cycle after that. A read is registered once, so its data and read-valid appear in the cycle after the request edge. The bench drives each request on a falling edge and removes it on the next falling edge, and samples every output at that second falling edge. It then waits one more falling edge after a reset pulse to confirm the pulse has dropped.

// File: rtl/bcr_pkg.sv
// Shared constants for the bridge control register bank.
// Assumes 32-bit words and byte addressing with 4 bytes per word.
package bcr_pkg;
    localparam int DW         = 32;
    localparam int WORD_BYTES = 4;
    localparam int REG_COUNT  = 28;
    localparam int IDX_W      = $clog2(REG_COUNT);
    localparam int WIN_BYTES  = REG_COUNT * WORD_BYTES;

    // Indexes whose behaviour differs from a plain stored word
    localparam int IX_GEN   = 1;
    localparam int IX_ENSET = 12;
    localparam int IX_ENCLR = 13;
    localparam int IX_EN    = 14;
    localparam int IX_ISR   = 15;

    // General configuration bit positions
    localparam int GEN_DBG     = 0;
    localparam int GEN_SNP     = 1;
    localparam int GEN_SELFRST = 2;
    localparam int GEN_SWAP    = 6;
    localparam int GEN_UNC     = 7;
    localparam int GEN_PREF    = 8;
    localparam int GEN_WBH     = 9;
    localparam int GEN_PQ      = 12;

    // Power-on value for each register index
    function automatic logic [DW-1:0] reset_value(input int idx);
        logic [DW-1:0] v;
        v = '0;
        case (idx)
            0:  v = 32'h0000_0C40;
            1: begin
                v[GEN_SELFRST] = 1'b1;
                v[GEN_UNC]     = 1'b1;
                v[GEN_PREF]    = 1'b1;
                v[GEN_WBH]     = 1'b1;
                v[GEN_PQ]      = 1'b1;
            end
            2:  v = 32'h2BFF_8010;
            3:  v = 32'h255E_0091;
            4:  v = 32'h0000_6140;
            7:  v = 32'h0000_01FF;
            8:  v = 32'h0000_01FF;
            26: v = 32'h0000_0008;
            27: v = 32'h1000_0000;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/bcr_addr_dec.sv
// Address decoder. Splits a byte address into a word index and a hit flag.
// A hit needs an aligned address that falls inside the register window.
module bcr_addr_dec
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int LSB_W = $clog2(WORD_BYTES);

    // Alignment and window check
    always_comb begin
        hit = (addr[LSB_W-1:0] == '0) && (int'(addr) < WIN_BYTES);
        idx = addr[IDX_W+LSB_W-1:LSB_W];
    end
endmodule

// File: rtl/bcr_enable_reg.sv
// Interrupt-enable word. Software reaches it only through the set and
// clear strobes. Assumes at most one strobe per cycle, which the decoder
// guarantees.
module bcr_enable_reg
    import bcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_stb,
    input  logic          clr_stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_word
);
    // OR in the set bits, or mask out the clear bits
    always_ff @(posedge clk) begin
        if (!rst_n)       en_word <= reset_value(IX_EN);
        else if (set_stb) en_word <= en_word | wdata;
        else if (clr_stb) en_word <= en_word & ~wdata;
    end
endmodule

// File: rtl/bcr_self_reset.sv
// Edge detector for the self-reset bit. Emits a one-cycle request when a
// write sets a bit that is stored as 0. Assumes cur_bit is the value held
// before the write.
module bcr_self_reset (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_wr,
    input  logic cur_bit,
    input  logic new_bit,
    output logic pulse
);
    // Register the 0-to-1 condition as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= gen_wr && !cur_bit && new_bit;
    end
endmodule

// File: rtl/bcr_word_bank.sv
// Storage for the register words. A generate picks the variant for each
// index: the enable word comes from outside, the status word is read-only
// zero, and every other word is a flop loaded with its power-on value.
module bcr_word_bank
    import bcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    en_word,
    output logic [DW-1:0]    words [REG_COUNT]
);
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_word
        if (i == IX_EN) begin : g_en
            assign words[i] = en_word;
        end else if (i == IX_ISR) begin : g_isr
            assign words[i] = '0;
        end else begin : g_flop
            logic [DW-1:0] q;
            // Plain word: reset to its default, load on an addressed write
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= reset_value(i);
                else if (wr_en && wr_idx == IDX_W'(i))     q <= wr_data;
            end
            assign words[i] = q;
        end
    end
endmodule

// File: rtl/bridge_ctl_regs.sv
// Bridge control register bank, top level. Decodes a simple request port,
// routes writes to storage, to the enable aliases or to the self-reset
// detector, and returns read data one cycle after a read request.
// Assumes one request per cycle and whole 32-bit words only.
module bridge_ctl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              sys_rst_req
);
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             wr_hit;
    logic             rd_req;
    logic             set_stb;
    logic             clr_stb;
    logic             gen_wr;
    logic             store_en;
    logic [DW-1:0]    en_word;
    logic [DW-1:0]    words [REG_COUNT];

    bcr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .hit  (hit),
        .idx  (idx)
    );

    // Classify the current request
    always_comb begin
        wr_hit   = req_valid && req_write && hit;
        rd_req   = req_valid && !req_write;
        set_stb  = wr_hit && (idx == IDX_W'(IX_ENSET));
        clr_stb  = wr_hit && (idx == IDX_W'(IX_ENCLR));
        gen_wr   = wr_hit && (idx == IDX_W'(IX_GEN));
        store_en = wr_hit;
    end

    bcr_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .wdata   (req_wdata),
        .en_word (en_word)
    );

    bcr_word_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .en_word (en_word),
        .words   (words)
    );

    bcr_self_reset u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_wr  (gen_wr),
        .cur_bit (words[IX_GEN][GEN_SELFRST]),
        .new_bit (req_wdata[GEN_SELFRST]),
        .pulse   (sys_rst_req)
    );

    // Registered read port; a miss reads as zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= hit ? words[idx] : '0;
        end
    end
endmodule

// File: rtl/bridge_ctl_regs_chk.sv
// Property checker for the bridge control register bank, attached by bind.
module bridge_ctl_regs_chk
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DW-1:0]     req_wdata,
    input logic              rd_valid,
    input logic [DW-1:0]     rd_data,
    input logic              sys_rst_req,
    input logic [DW-1:0]     en_word
);
    logic wr, rd, bad;
    always_comb begin
        wr  = req_valid && req_write;
        rd  = req_valid && !req_write;
        bad = (req_addr[1:0] != 2'b00) || (int'(req_addr) >= WIN_BYTES);
    end

    assert_rdvalid_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid);
    assert_no_rdvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rd_valid);
    assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(IX_ENSET * WORD_BYTES))
        |=> en_word == ($past(en_word) | $past(req_wdata)));
    assert_enable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(IX_ENCLR * WORD_BYTES))
        |=> en_word == ($past(en_word) & ~$past(req_wdata)));
    assert_enable_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'(IX_EN * WORD_BYTES)) |=> $stable(en_word));
    assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(wr && req_addr == ADDR_W'(IX_GEN * WORD_BYTES)
                              && req_wdata[GEN_SELFRST]));
    assert_reset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);
    assert_bad_write_keeps_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bad) |=> $stable(en_word));
    assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bad) |=> rd_data == '0);
endmodule

bind bridge_ctl_regs bridge_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .sys_rst_req (sys_rst_req),
    .en_word     (en_word)
);

// File: tb/bridge_ctl_regs_test.sv
module bridge_ctl_regs_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          sys_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [28];

    always #4 clk = ~clk;

    bridge_ctl_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .sys_rst_req(sys_rst_req)
    );

    function automatic logic [31:0] dflt(input int i);
        case (i)
            0: return 32'h0000_0C40;  1: return 32'h0000_1384;
            2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
            4: return 32'h0000_6140;  7: return 32'h0000_01FF;
            8: return 32'h0000_01FF;  26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit good(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && (int'(a) < 112);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        logic pulse_exp;
        int i;
        i = int'(a) >> 2;
        pulse_exp = good(a) && i == 1 && !model[1][2] && d[2];
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(pulse_exp ? "R7" : "R8", $sformatf("reset request after write %h", a),
              {31'b0, sys_rst_req}, {31'b0, pulse_exp});
        check("R10", "rd_valid after write", {31'b0, rd_valid}, 32'h0);
        if (pulse_exp) begin
            @(negedge clk);
            check("R7", "reset request drops", {31'b0, sys_rst_req}, 32'h0);
        end
        if (good(a)) begin
            case (i)
                14, 15: ;
                12: begin model[12] = d; model[14] = model[14] | d; end
                13: begin model[13] = d; model[14] = model[14] & ~d; end
                default: model[i] = d;
            endcase
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        logic [31:0] exp;
        exp = good(a) ? model[int'(a) >> 2] : 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "rd_valid on read", {31'b0, rd_valid}, 32'h1);
        check(req, $sformatf("read %h", a), rd_data, exp);
        @(negedge clk);
        check("R10", "rd_valid idle", {31'b0, rd_valid}, 32'h0);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 28; i++) do_read(AW'(i * 4), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 28; i++) model[i] = dflt(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "no reset request after reset", {31'b0, sys_rst_req}, 32'h0);
        check("R10", "rd_valid after reset", {31'b0, rd_valid}, 32'h0);
        read_all("R2");

        // R3/R4/R5/R6: distinct pattern into every aligned offset, window included
        for (int i = 0; i < 32; i++)
            do_write(AW'(i * 4), {8'(i), 8'(i * 7 + 3), 8'(~i), 8'hA5 ^ 8'(i)});
        read_all("R3");
        for (int i = 28; i < 64; i++) do_read(AW'(i * 4), "R9");

        // R9: misaligned writes leave every word unchanged
        for (int i = 0; i < 28; i++)
            for (int k = 1; k < 4; k++)
                do_write(AW'(i * 4 + k), 32'hDEAD_0000 | 32'(i * 4 + k));
        read_all("R9");
        for (int k = 1; k < 4; k++) do_read(AW'(8 + k), "R9");

        // R4/R5: set and clear sequences on the enable word
        do_write(8'h34, 32'hFFFF_FFFF);
        do_read(8'h38, "R5");
        do_write(8'h30, 32'h0000_00F0);
        do_read(8'h38, "R4");
        do_write(8'h30, 32'h8000_000F);
        do_read(8'h38, "R4");
        do_read(8'h30, "R4");
        do_write(8'h34, 32'h0000_0030);
        do_read(8'h38, "R5");
        do_read(8'h34, "R5");
        do_write(8'h38, 32'h0000_0000);
        do_read(8'h38, "R6");
        do_write(8'h3C, 32'hFFFF_FFFF);
        do_read(8'h3C, "R6");

        // R7/R8: self-reset bit edge cases
        do_write(8'h04, 32'h0000_0004);
        do_write(8'h04, 32'h0000_0000);
        do_write(8'h04, 32'h0000_FFFB);
        do_write(8'h04, 32'h0000_0004);
        do_read(8'h04, "R7");
        do_write(8'h04, 32'hFFFF_FFFF);
        do_write(8'h05, 32'h0000_0000);
        do_write(8'h04, 32'h0000_0000);
        do_write(8'h06, 32'h0000_0004);
        do_write(8'h04, 32'hFFFF_FFFF);
        do_read(8'h04, "R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule